// File: doc/BRIEF.md
# Block-Floating-Point Peak Range Detector

This block watches every data word that the processor writes during one pass of a fixed-point FFT. It sorts each word into a range class by the size of its upper byte. It also keeps a sticky record of the largest class seen since the record was last cleared. The record appears as two flags. One says the next pass must scale its data down by four. The other says it must scale down by at least two.

Between passes, the processor samples the two flags to choose the scale factor for the next pass. It clears them with the same read strobe, so a new pass starts from an empty record. The block does none of the scaling arithmetic.

A word's magnitude is its upper byte XOR-ed with copies of that byte's sign bit. The two magnitude thresholds are parameters. By default, a word that reaches into the upper of the two guard bits asks for divide-by-4. A word that reaches only into the lower guard bit asks for divide-by-2.

Top module: `bfp_peak_range`

## Requirements
- R1: A synchronous active-high reset clears both flags at the clock edge where it is sampled, even when a write is present at that edge.
- R2: Only the upper byte (bits 15:8 by default) of a written word affects the flags. The lower bits have no effect.
- R3: The magnitude is the upper byte XOR-ed with eight copies of bit 15. A written word whose magnitude is at least 0x40 sets the divide-by-4 class.
- R4: A written word whose magnitude is at least 0x20 but below 0x40 sets the divide-by-2 class.
- R5: A written word whose magnitude is below 0x20 raises no flag.
- R6: Negative words are classed by the same magnitude. Upper byte 0x80 or 0xBF gives divide-by-4, 0xC0 or 0xDF gives divide-by-2, and 0xE0 gives no class.
- R7: The flags hold the largest class written since the last clear. A later write of a smaller class does not lower them.
- R8: Divide-by-4 has priority over divide-by-2. Whenever the divide-by-4 flag is high, the divide-by-2 flag is also high.
- R9: A write sampled at a clock edge shows on the flags right after that edge. The flags are unchanged before that edge.
- R10: A read/clear sampled at an edge empties the record. The flags before that edge are the old result. A write at the same edge is the first entry of the new record, so the flags afterwards show only that write's class.
- R11: With the write strobe low, the data input is ignored and the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data write strobe, one word per cycle |
| wr_data | input | 16 | Word being written (DATA_W) |
| rd_clr | input | 1 | Read-and-clear strobe for the flags |
| div4_o | output | 1 | Divide-by-4 needed |
| div2_o | output | 1 | Divide-by-2 (or more) needed |

## Verification
The flags come from a single register stage, so every write, clear or reset sampled at a rising edge is due on the flags one time step after that edge. The bench drives inputs at the falling edge and samples the flags 1 ns after the following rising edge. To check that nothing changes early, it also samples the flags just before the edge at which a write is taken. For a read/clear that coincides with a write, it checks the old flags before the edge and the new record after it.

// File: rtl/bfp_peak_pkg.sv
package bfp_peak_pkg;

    // Range classes, ordered so a larger code means a larger peak
    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_DIV2 = 2'd1,
        RC_DIV4 = 2'd2
    } rng_class_t;

    function automatic rng_class_t rng_max(input rng_class_t a, input rng_class_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic cls_is_div4(input rng_class_t c);
        return c == RC_DIV4;
    endfunction

    function automatic logic cls_is_div2(input rng_class_t c);
        return c != RC_NONE;
    endfunction

endpackage

// File: rtl/bfp_range_classify.sv
module bfp_range_classify
    import bfp_peak_pkg::*;
#(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned MAG_DIV4 = 'h40,
    parameter int unsigned MAG_DIV2 = 'h20
) (
    input  logic [BYTE_W-1:0] top_byte,
    output rng_class_t        cls
);
    localparam logic [BYTE_W-1:0] THR4 = BYTE_W'(MAG_DIV4);
    localparam logic [BYTE_W-1:0] THR2 = BYTE_W'(MAG_DIV2);

    logic              sgn;
    logic [BYTE_W-1:0] mag;

    always_comb begin
        sgn = top_byte[BYTE_W-1];
        mag = top_byte ^ {BYTE_W{sgn}};
        if (mag >= THR4)      cls = RC_DIV4;
        else if (mag >= THR2) cls = RC_DIV2;
        else                  cls = RC_NONE;
    end
endmodule

// File: rtl/bfp_peak_hold.sv
module bfp_peak_hold
    import bfp_peak_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       clear,
    input  rng_class_t new_cls,
    output rng_class_t held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= RC_NONE;
        else if (clear)
            held <= take ? new_cls : RC_NONE;
        else if (take)
            held <= rng_max(held, new_cls);
    end

    // R7: a held divide-by-4 survives any write until a clear
    a_r7_div4_sticky: assert property (@(posedge clk) disable iff (rst)
        (held == RC_DIV4 && !clear) |=> held == RC_DIV4);

    // R11: without a strobe nothing moves
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!take && !clear) |=> $stable(held));

    // R10: a lone clear empties the record
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clear && !take) |=> held == RC_NONE);
endmodule

// File: rtl/bfp_peak_range.sv
module bfp_peak_range
    import bfp_peak_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned MAG_DIV4 = 'h40,
    parameter int unsigned MAG_DIV2 = 'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clr,
    output logic              div4_o,
    output logic              div2_o
);
    localparam int unsigned TOP_LSB = DATA_W - BYTE_W;

    rng_class_t word_cls;
    rng_class_t held_cls;

    bfp_range_classify #(
        .BYTE_W  (BYTE_W),
        .MAG_DIV4(MAG_DIV4),
        .MAG_DIV2(MAG_DIV2)
    ) u_cls (
        .top_byte(wr_data[DATA_W-1:TOP_LSB]),
        .cls     (word_cls)
    );

    bfp_peak_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .take   (wr_en),
        .clear  (rd_clr),
        .new_cls(word_cls),
        .held   (held_cls)
    );

    assign div4_o = cls_is_div4(held_cls);
    assign div2_o = cls_is_div2(held_cls);

    // R8: divide-by-4 always carries divide-by-2 with it
    a_r8_div4_implies_div2: assert property (@(posedge clk) disable iff (rst)
        div4_o |-> div2_o);

    // R1: reset leaves both flags low
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!div4_o && !div2_o));

    // R5: a small word written after a clear leaves the flags low
    a_r5_small_no_flag: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && wr_en && word_cls == RC_NONE) |=> (!div2_o && !div4_o));
endmodule

// File: tb/bfp_peak_range_tb.sv
module bfp_peak_range_tb;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic        clr;
        logic        wr;
        logic [15:0] data;
        logic        e4;
        logic        e2;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'h1FFF, 1'b0, 1'b0, 8'd5},  // R5 mag 0x1F
        '{1'b0, 1'b1, 16'h2000, 1'b0, 1'b1, 8'd4},  // R4 mag 0x20
        '{1'b0, 1'b1, 16'h0005, 1'b0, 1'b1, 8'd7},  // R7 smaller keeps
        '{1'b0, 1'b0, 16'h7FFF, 1'b0, 1'b1, 8'd11}, // R11 no strobe
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd10}, // R10 clear
        '{1'b0, 1'b1, 16'hE0FF, 1'b0, 1'b0, 8'd6},  // R6 0xE0 none
        '{1'b0, 1'b1, 16'hDF00, 1'b0, 1'b1, 8'd6},  // R6 0xDF div2
        '{1'b0, 1'b1, 16'h4000, 1'b1, 1'b1, 8'd3},  // R3 mag 0x40
        '{1'b0, 1'b1, 16'h2100, 1'b1, 1'b1, 8'd8},  // R8 div4 keeps div2
        '{1'b1, 1'b1, 16'h3000, 1'b0, 1'b1, 8'd10}, // R10 clear + write
        '{1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 8'd10}, // R10 clear + small
        '{1'b0, 1'b1, 16'h8000, 1'b1, 1'b1, 8'd6},  // R6 0x80 div4
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd10}, // R10 clear
        '{1'b0, 1'b1, 16'hBFFF, 1'b1, 1'b1, 8'd6},  // R6 0xBF div4
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd10}, // R10 clear
        '{1'b0, 1'b1, 16'hC000, 1'b0, 1'b1, 8'd6}   // R6 0xC0 div2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_clr = 1'b0;
    logic        div4_o;
    logic        div2_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfp_peak_range u_dut (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_clr (rd_clr),
        .div4_o (div4_o),
        .div2_o (div2_o)
    );

    task automatic check(input logic e4, input logic e2, input int req);
        checks++;
        if (div4_o !== e4 || div2_o !== e2) begin
            errors++;
            $display("FAIL R%0d: div4/div2 = %b%b expected %b%b at %0t",
                     req, div4_o, div2_o, e4, e2, $time);
        end
    endtask

    // drive at falling edge, take one rising edge, sample 1 ns later
    task automatic step(input logic c, input logic w, input logic [15:0] d);
        @(negedge clk);
        rd_clr = c; wr_en = w; wr_data = d;
        @(posedge clk);
        #1ns;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        step(1'b0, 1'b0, 16'h0000);
        step(1'b0, 1'b0, 16'h0000);
        check(1'b0, 1'b0, 1); // R1
        @(negedge clk) rst = 1'b0;

        foreach (VECS[i]) begin
            step(VECS[i].clr, VECS[i].wr, VECS[i].data);
            check(VECS[i].e4, VECS[i].e2, int'(VECS[i].req));
        end
        step(1'b1, 1'b0, 16'h0000);
        check(1'b0, 1'b0, 10);

        // R2: lower byte sweep never moves a class boundary
        for (int lo = 0; lo < 256; lo += 17) begin
            step(1'b0, 1'b1, {8'h1F, 8'(lo)});
        end
        check(1'b0, 1'b0, 2); // R2 0x1Fxx stays below
        for (int lo = 255; lo >= 0; lo -= 51) begin
            step(1'b1, 1'b1, {8'h3F, 8'(lo)});
            check(1'b0, 1'b1, 2); // R2 0x3Fxx stays div2
        end

        // R9: write not visible before its edge, visible right after
        step(1'b1, 1'b0, 16'h0000);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 16'h7F00;
        #1ns;
        check(1'b0, 1'b0, 9); // R9 before edge
        @(posedge clk); #1ns;
        check(1'b1, 1'b1, 9); // R9 after edge

        // R10: clear with coincident write reads old flags before the edge
        @(negedge clk);
        rd_clr = 1'b1; wr_en = 1'b1; wr_data = 16'h2200;
        #1ns;
        check(1'b1, 1'b1, 10); // R10 old value still readable
        @(posedge clk); #1ns;
        check(1'b0, 1'b1, 10); // R10 only the new write

        // R1: reset wins over a large write
        step(1'b0, 1'b1, 16'h7FFF);
        check(1'b1, 1'b1, 3);
        @(negedge clk);
        rst = 1'b1; rd_clr = 1'b0; wr_en = 1'b1; wr_data = 16'h7FFF;
        @(posedge clk); #1ns;
        check(1'b0, 1'b0, 1); // R1 reset with write
        @(negedge clk) begin rst = 1'b0; wr_en = 1'b0; end

        // R11: data toggles with strobe low after a div2 record
        step(1'b0, 1'b1, 16'h2F00);
        step(1'b0, 1'b0, 16'h8000);
        step(1'b0, 1'b0, 16'h7FFF);
        check(1'b0, 1'b1, 11); // R11 ignored
        step(1'b0, 1'b0, 16'h0000);
        finish_run();
    end
endmodule